// File: doc/BRIEF.md
# Digital PLL Bit-Clock Recovery

This block recovers bit timing from a serial data line. It runs on a reference clock at sixteen times the nominal bit rate. A 4-bit phase counter spans one bit cell. The line is synchronized and edge-detected. Each detected edge is classified by the counter value at which it is seen. Depending on that value, the cell in progress is lengthened or shortened by one or two counts, or left unchanged. The aim is to keep the counter's cell boundary aligned with the data.

A mode input selects the edge map. In NRZ/NRZI mode, edges are expected at the cell boundary and data is taken at mid-cell. In biphase-level mode, the block locks onto the transition that is guaranteed at every cell centre, and it disregards edges near the boundary.

The block has three outputs:
- a recovered clock;
- a one-cycle sample strobe;
- a lock flag, which rises after a run of cells that needed no correction.

A downstream decoder uses the strobe to capture line data.

Top module: `dpll_clock_recovery`

## Requirements
- R1: While reset is asserted, and on its release, the phase counter is 0, recClk is 1, sampleEn is 0 and locked is 0.
- R2: With no line edges, the counter advances by one per reference clock and wraps from 15 to 0. sampleEn is then a single-cycle pulse every 16 cycles, and recClk is 1 for counts 0 to 7 and 0 for counts 8 to 15.
- R3: sampleEn is high exactly while the counter is 8 when modeBiphase=0, and exactly while it is 4 when modeBiphase=1.
- R4: A change on dataIn passes through a two-flop synchronizer. It is classified at the counter value present two reference clocks after the change is registered by the first flop's input edge; that is, the value two cycles after the value seen when the change is applied.
- R5: A correction acts on the clock edge after the edge is classified at count p. Lengthen-by-one makes the next count p. Lengthen-by-two makes it p-1. Shorten-by-one makes it p+2 (mod 16). Shorten-by-two makes it p+3 (mod 16).
- R6: With modeBiphase=0, edges classified at counts 2-4 lengthen by one and counts 5-7 lengthen by two. Counts 8-10 shorten by two and counts 11-14 shorten by one. Counts 15, 0 and 1 cause no change.
- R7: With modeBiphase=1, edges at counts 10-12 lengthen by one, edges at counts 4-6 shorten by one, and edges at counts 7-9 cause no change.
- R8: With modeBiphase=1, edges at counts 13-15 and 0-3 are ignored, leaving the sample strobe timing unchanged.
- R9: At most one correction is applied per cell. A cell ends when the counter crosses from 15 to 0, including a crossing made by a shorten step. A later edge in the same cell has no effect.
- R10: locked rises at the end of the eighth consecutive cell in which no correction was applied. A correction resets this run count.
- R11: A two-count correction clears locked at once. A one-count correction leaves locked unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, sixteen times the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 1 | Serial line, asynchronous to clk |
| modeBiphase | input | 1 | 0: NRZ/NRZI edge map; 1: biphase-level edge map |
| recClk | output | 1 | Recovered bit clock, high in the first half of the cell |
| sampleEn | output | 1 | One-cycle strobe at the data sampling point |
| locked | output | 1 | Phase lock indicator |

## Verification
In each mode, a single edge is placed at every one of the sixteen counter values from a fresh reset, and the timing of the next two sample strobes is compared with arithmetic predictions. This exercise separates the no-change, one-count and two-count regions, the lengthen and shorten directions, and the biphase ignore window. A second edge inside an already corrected cell shows whether the once-per-cell rule holds. Free-running stretches confirm the strobe period, the recovered clock duty and the sample point in each mode. Lock sequences then show the eight-cell threshold, tolerance of a one-count step, loss of lock on a two-count step, and reacquisition.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef struct packed {
    logic lenOne;
    logic lenTwo;
    logic shrOne;
    logic shrTwo;
  } ctrlStrobes_t;
endpackage

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeBiphase,
  input  ctrlStrobes_t     strb,
  output logic [CNT_W-1:0] phase,
  output logic             cellWrap,
  output logic             recClk,
  output logic             sampleEn
);
  localparam int CELL  = 2 ** CNT_W;
  localparam int HALF  = CELL / 2;
  localparam int QUART = CELL / 4;
  localparam logic [CNT_W-1:0] HALF_PT  = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] QUART_PT = CNT_W'(QUART);

  logic [1:0]       incr;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nextPhase;

  always_comb begin
    if (strb.lenOne)      incr = 2'd0;
    else if (strb.shrOne) incr = 2'd2;
    else if (strb.shrTwo) incr = 2'd3;
    else                  incr = 2'd1;
    sum = {1'b0, phase} + (CNT_W + 1)'(incr);
    if (strb.lenTwo) begin
      nextPhase = phase - CNT_W'(1);
      cellWrap  = 1'b0;
    end else begin
      nextPhase = sum[CNT_W-1:0];
      cellWrap  = sum[CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= nextPhase;
  end

  assign recClk   = (phase < HALF_PT);
  assign sampleEn = (phase == (modeBiphase ? QUART_PT : HALF_PT));
endmodule

// File: rtl/dpll_control.sv
module dpll_control
  import dpll_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int LOCK_CELLS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic             modeBiphase,
  input  logic [CNT_W-1:0] phase,
  input  logic             cellWrap,
  output ctrlStrobes_t     strb,
  output logic             locked
);
  localparam int CELL  = 2 ** CNT_W;
  localparam int HALF  = CELL / 2;
  localparam int QUART = CELL / 4;
  localparam int RUN_W = $clog2(LOCK_CELLS + 1);
  localparam logic [CNT_W-1:0] N_LEN1_LO = CNT_W'(2);
  localparam logic [CNT_W-1:0] N_LEN1_HI = CNT_W'(QUART);
  localparam logic [CNT_W-1:0] N_LEN2_HI = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] N_SHR2_LO = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] N_SHR2_HI = CNT_W'(HALF + QUART - 2);
  localparam logic [CNT_W-1:0] N_SHR1_HI = CNT_W'(CELL - 2);
  localparam logic [CNT_W-1:0] B_SHR1_LO = CNT_W'(QUART);
  localparam logic [CNT_W-1:0] B_SHR1_HI = CNT_W'(HALF - 2);
  localparam logic [CNT_W-1:0] B_LEN1_LO = CNT_W'(HALF + 2);
  localparam logic [CNT_W-1:0] B_LEN1_HI = CNT_W'(HALF + QUART);

  logic syncA, syncB, syncC;
  logic edgeSeen, corrDone, corrAny, twoStep, cleanCell;
  logic [RUN_W-1:0] runCnt;
  ctrlStrobes_t want;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) {syncA, syncB, syncC} <= '0;
    else       {syncA, syncB, syncC} <= {dataIn, syncA, syncB};
  end
  assign edgeSeen = syncB ^ syncC;

  always_comb begin
    want = '0;
    if (!modeBiphase) begin
      if (phase >= N_LEN1_LO && phase <= N_LEN1_HI)      want.lenOne = 1'b1;
      else if (phase > N_LEN1_HI && phase <= N_LEN2_HI)  want.lenTwo = 1'b1;
      else if (phase >= N_SHR2_LO && phase <= N_SHR2_HI) want.shrTwo = 1'b1;
      else if (phase > N_SHR2_HI && phase <= N_SHR1_HI)  want.shrOne = 1'b1;
    end else begin
      if (phase >= B_SHR1_LO && phase <= B_SHR1_HI)      want.shrOne = 1'b1;
      else if (phase >= B_LEN1_LO && phase <= B_LEN1_HI) want.lenOne = 1'b1;
    end
    strb = (edgeSeen && !corrDone) ? want : '0;
  end

  assign corrAny   = |strb;
  assign twoStep   = strb.lenTwo | strb.shrTwo;
  assign cleanCell = !(corrDone || corrAny);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corrDone <= 1'b0;
      runCnt   <= '0;
      locked   <= 1'b0;
    end else begin
      corrDone <= cellWrap ? 1'b0 : (corrDone | corrAny);
      if (cellWrap) begin
        if (!cleanCell)                       runCnt <= '0;
        else if (runCnt < RUN_W'(LOCK_CELLS)) runCnt <= runCnt + RUN_W'(1);
      end
      if (twoStep)
        locked <= 1'b0;
      else if (cellWrap && cleanCell && runCnt >= RUN_W'(LOCK_CELLS - 1))
        locked <= 1'b1;
    end
  end
endmodule

// File: rtl/dpll_clock_recovery.sv
module dpll_clock_recovery
  import dpll_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int LOCK_CELLS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataIn,
  input  logic modeBiphase,
  output logic recClk,
  output logic sampleEn,
  output logic locked
);
  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] phase;
  logic             cellWrap;

  dpll_control #(.CNT_W(CNT_W), .LOCK_CELLS(LOCK_CELLS)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .modeBiphase(modeBiphase),
    .phase(phase), .cellWrap(cellWrap), .strb(strb), .locked(locked)
  );

  dpll_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .modeBiphase(modeBiphase), .strb(strb),
    .phase(phase), .cellWrap(cellWrap), .recClk(recClk), .sampleEn(sampleEn)
  );
endmodule

// File: rtl/dpll_checker.sv
module dpll_checker
  import dpll_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeBiphase,
  input logic             recClk,
  input logic             sampleEn,
  input logic             locked,
  input logic [CNT_W-1:0] phase,
  input ctrlStrobes_t     strb
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] THREE = CNT_W'(3);

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> !sampleEn);

  assert_sample_point_R3: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> (recClk == modeBiphase));

  assert_hold_lengthen_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.lenOne |=> (phase == $past(phase)));

  assert_back_lengthen_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.lenTwo |=> (phase == $past(phase) - ONE));

  assert_skip_shorten_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.shrTwo |=> (phase == $past(phase) + THREE));

  assert_biphase_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    modeBiphase |-> !(strb.lenTwo || strb.shrTwo));

  assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  assert_lock_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(strb.lenTwo || strb.shrTwo));
endmodule

bind dpll_clock_recovery dpll_checker #(.CNT_W(CNT_W)) u_check (
  .clk(clk), .rstN(rstN), .modeBiphase(modeBiphase), .recClk(recClk),
  .sampleEn(sampleEn), .locked(locked), .phase(phase), .strb(strb)
);

// File: tb/tb_dpll_clock_recovery.sv
`timescale 1ns/1ps
module tb_dpll_clock_recovery;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b0;
  logic modeBiphase = 1'b0;
  logic recClk, sampleEn, locked;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  dpll_clock_recovery dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .modeBiphase(modeBiphase),
    .recClk(recClk), .sampleEn(sampleEn), .locked(locked)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input bit bi);
    rstN = 1'b0;
    dataIn = 1'b0;
    modeBiphase = bi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitSample();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!sampleEn && guard < 100);
  endtask

  function automatic int md(input int x);
    return ((x % 16) + 16) % 16;
  endfunction

  // lengthen amount (positive) or shorten amount (negative) from the maps
  function automatic int expAdj(input bit bi, input int p);
    if (!bi) begin
      if (p >= 2 && p <= 4)   return 1;
      if (p >= 5 && p <= 7)   return 2;
      if (p >= 8 && p <= 10)  return -2;
      if (p >= 11 && p <= 14) return -1;
      return 0;
    end
    if (p >= 4 && p <= 6)   return -1;
    if (p >= 10 && p <= 12) return 1;
    return 0;
  endfunction

  function automatic int phaseAt(input int p, input int adj, input int t);
    if (t == 1) return md(p - 1);
    if (t == 2) return p;
    return md(p + 1 - adj + t - 3);
  endfunction

  task automatic edgeTrial(input bit bi, input int p);
    int sPt, n, adj, e1, e2, a1, a2;
    string tag;
    sPt = bi ? 4 : 8;
    adj = expAdj(bi, p);
    if (!bi) tag = (adj == 0) ? "R4 R6" : "R4 R5 R6";
    else if (p >= 7 && p <= 9) tag = "R4 R7";
    else tag = (adj == 0) ? "R4 R8" : "R4 R5 R7";
    e1 = 0; e2 = 0; a1 = 0; a2 = 0;
    for (int t = 1; t <= 45; t++) begin
      if (phaseAt(p, adj, t) == sPt) begin
        if (e1 == 0) e1 = t;
        else if (e2 == 0) e2 = t;
      end
    end
    doReset(bi);
    waitSample();
    n = md(p - sPt - 2);
    repeat (n) @(negedge clk);
    dataIn = ~dataIn;
    for (int t = 1; t <= 45; t++) begin
      @(negedge clk);
      if (sampleEn) begin
        if (a1 == 0) a1 = t;
        else if (a2 == 0) a2 = t;
      end
    end
    chk(a1 == e1, $sformatf("%s mode=%0d edge@%0d first strobe", tag, bi, p), a1, e1);
    chk(a2 == e2, $sformatf("%s mode=%0d edge@%0d second strobe", tag, bi, p), a2, e2);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int gap, high, first;
    bit prevClk;
    // R1: reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(recClk == 1'b1, "R1 recClk in reset", recClk, 1);
    chk(sampleEn == 1'b0, "R1 sampleEn in reset", sampleEn, 0);
    chk(locked == 1'b0, "R1 locked in reset", locked, 0);

    // R2/R3 NRZ free run
    doReset(1'b0);
    chk(recClk == 1'b1 && sampleEn == 1'b0, "R1 state at release", recClk, 1);
    waitSample();
    gap = 0; high = 0; prevClk = recClk;
    chk(recClk == 1'b0, "R3 NRZ strobe at count 8 (recClk low)", recClk, 0);
    do begin
      @(negedge clk);
      gap++;
      if (gap == 15) prevClk = recClk;
      if (recClk) high++;
    end while (!sampleEn && gap < 40);
    chk(gap == 16, "R2 NRZ strobe period", gap, 16);
    chk(high == 8, "R2 recClk high counts per cell", high, 8);
    chk(prevClk == 1'b1, "R2 recClk high at count 7", prevClk, 1);

    // R3 biphase sample point
    doReset(1'b1);
    waitSample();
    chk(recClk == 1'b1, "R3 biphase strobe in first half", recClk, 1);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (recClk && gap < 40);
    chk(gap == 4, "R3 biphase strobe four counts before mid-cell", gap, 4);

    // R4-R8 sweep of all edge positions in both modes
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 16; p++)
        edgeTrial(m[0], p);

    // R9 second edge in a corrected cell is ignored
    doReset(1'b0);
    waitSample();
    repeat (9) @(negedge clk);
    dataIn = ~dataIn;
    first = 0;
    for (int t = 1; t <= 20; t++) begin
      @(negedge clk);
      if (sampleEn && first == 0) first = t;
      if (t == 3) dataIn = ~dataIn;
    end
    chk(first == 8, "R9 one correction per cell", first, 8);

    // R10 lock after eight clean cells
    doReset(1'b0);
    for (int k = 1; k <= 9; k++) begin
      waitSample();
      if (k == 8) chk(locked == 1'b0, "R10 not locked after seven cells", locked, 0);
      if (k == 9) chk(locked == 1'b1, "R10 locked after eight cells", locked, 1);
    end
    // R11 one-count step keeps lock
    repeat (9) @(negedge clk);
    dataIn = ~dataIn;
    waitSample();
    chk(locked == 1'b1, "R11 lock kept on one-count step", locked, 1);
    // R11 two-count step clears lock
    repeat (12) @(negedge clk);
    dataIn = ~dataIn;
    waitSample();
    chk(locked == 1'b0, "R11 lock cleared on two-count step", locked, 0);
    // R10 reacquire
    for (int k = 1; k <= 9; k++) begin
      waitSample();
      if (k == 8) chk(locked == 1'b0, "R10 relock not before eight clean cells", locked, 0);
      if (k == 9) chk(locked == 1'b1, "R10 relock after eight clean cells", locked, 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule